// File: doc/BRIEF.md
# Configurable SPI Slave Engine

This block lets a chip act as the target device on an SPI link. An external master supplies the serial clock, the select line and the master-to-slave data line. The engine shifts received bits into a word register and returns the contents of a transmit buffer on the slave-to-master line. That output is enabled only while the device is selected. The core clock oversamples all three link inputs through a synchronizer chain and detects their edges in its own domain. For this reason the incoming serial clock must run no faster than one eighth of the core clock.

Software-side logic programs the following settings:
- the word length, from 8 to 32 bits;
- MSB-first or LSB-first order;
- the idle level of the serial clock;
- whether data is captured on the first or the second edge of each bit;
- the active level of the select line.

With the second-edge phase the engine starts a word on the first clock edge it sees while selected. It then keeps receiving words back to back for as long as select stays active. With the first-edge phase, exactly one word is exchanged per select assertion.

Each completed word lands in a holding register and raises a full flag. The consumer clears that flag with a one-cycle read strobe. If a further word completes while the register is still full, that word is dropped and an overrun flag is raised.

Top module: `spi_slave_core`

## Requirements
- R1: The leading edge of the serial clock is the transition away from the idle level `cfg_cpol`, and the trailing edge is the transition back to it. With `cfg_cpha`=0 the input is sampled on leading edges and the output changes on trailing edges. With `cfg_cpha`=1 the output changes on leading edges and the input is sampled on trailing edges.
- R2: `spi_miso_oe` is 1 only while the engine is enabled and the synchronized select is active. Otherwise it is 0, meaning the line is high impedance. The flag is 0 after reset.
- R3: The word length is `cfg_word_len`. Values below 8 act as 8 and values above 32 act as 32. Bits of `rx_data` above the word length read 0.
- R4: With `cfg_lsb_first`=0 the most significant bit of the word travels first in both directions. With `cfg_lsb_first`=1 bit 0 travels first.
- R5: With `cfg_sel_high`=1 the select input is active when high. With `cfg_sel_high`=0 it is active when low.
- R6: With `cfg_cpha`=0 a word starts when select becomes active, and its first output bit is presented before the first clock edge. Only one word is exchanged per assertion, and further clock edges are ignored until select is released and asserted again.
- R7: With `cfg_cpha`=1 a word starts on a leading edge while selected. Words follow one another under a single select assertion, and each word sends the transmit buffer contents present at its first leading edge.
- R8: A completed word is placed in `rx_data` and sets `rx_full`. A one-cycle `rx_read` pulse clears `rx_full`, unless another word completes in that same cycle. Both flags are 0 after reset.
- R9: If a word completes while `rx_full` is set and no read is present, `rx_overrun` goes to 1. The new word is discarded and `rx_data` keeps the unread word. `rx_read` clears `rx_overrun`.
- R10: While `cfg_enable`=0, `tx_write` is ignored (the transmit buffer keeps its value) and no word is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_sel_high | input | 1 | Select active level |
| cfg_word_len | input | 6 | Word length in bits (clamped 8..32) |
| tx_data | input | 32 | Value for the transmit buffer |
| tx_write | input | 1 | Load strobe for the transmit buffer |
| rx_data | output | 32 | Last accepted received word |
| rx_full | output | 1 | Unread word present |
| rx_read | input | 1 | Consumer read strobe |
| rx_overrun | output | 1 | A word was dropped while full |
| spi_sclk | input | 1 | Serial clock from master |
| spi_mosi | input | 1 | Data from master |
| spi_sel | input | 1 | Slave select from master |
| spi_miso | output | 1 | Data to master |
| spi_miso_oe | output | 1 | Output enable for the data-to-master pad |

## Verification
The checker watches, on every cycle, the following properties:
- the output enable stays low after select has been inactive long enough to pass the synchronizer;
- a read with no concurrent completion empties the holding register;
- a full register with no read keeps both its flag and its data;
- overrun can only rise while full;
- no word lands while disabled;
- the bit counter stays below the clamped length.

Only the bench scenarios can show that bits arrive in the right order on the right edge for each clock mode. The same holds for the start rules for each phase: one word per select in first-edge phase, continuous bursts in second-edge phase. The remaining scenario-only checks are the length clamping, the select polarity, and that a disabled engine neither loads its buffer nor captures words.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   // Link timing mode as seen by the shift engine
   typedef struct packed {
      logic cpol;
      logic cpha;
      logic lsb_first;
   } spi_mode_t;

   // Index of each synchronized link input inside the synchronizer vector
   localparam int unsigned LINK_SCLK = 0;
   localparam int unsigned LINK_MOSI = 1;
   localparam int unsigned LINK_SEL  = 2;
   localparam int unsigned LINK_N    = 3;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_slv_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic [WIDTH-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_st[g-1].r;
         end
      end
   end

   assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise,
   output logic fall
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= d;
   end

   assign rise = d & ~prev_q;
   assign fall = ~d & prev_q;

endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              start,
   input  logic              lead,
   input  logic              trail,
   input  spi_mode_t         mode,
   input  logic [LEN_W-1:0]  len,
   input  logic              mosi,
   input  logic [DATA_W-1:0] tx_buf,
   output logic              miso_bit,
   output logic              word_done,
   output logic [DATA_W-1:0] rx_word,
   output logic [LEN_W-1:0]  bit_cnt
);

   logic              in_word_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [DATA_W-1:0] tx_q, rx_q;
   logic [DATA_W-1:0] tx_load, tx_next, rx_next, rx_mask;
   logic              sample_edge, shift_edge, can_sample, can_shift, last_bit;

   // Edge roles follow the phase setting
   assign sample_edge = mode.cpha ? trail : lead;
   assign shift_edge  = mode.cpha ? lead  : trail;

   // Load aligns the word so the first bit sits at the output tap
   assign tx_load  = mode.lsb_first ? tx_buf : (tx_buf << (DATA_W - len));
   assign tx_next  = mode.lsb_first ? (tx_q >> 1) : (tx_q << 1);
   assign miso_bit = mode.lsb_first ? tx_q[0] : tx_q[DATA_W-1];

   assign rx_next  = mode.lsb_first ? {mosi, rx_q[DATA_W-1:1]}
                                    : {rx_q[DATA_W-2:0], mosi};
   assign rx_mask  = ~({DATA_W{1'b1}} << len);
   assign rx_word  = (mode.lsb_first ? (rx_next >> (DATA_W - len)) : rx_next) & rx_mask;

   assign last_bit   = (cnt_q == len - LEN_W'(1));
   assign can_sample = active & (mode.cpha | in_word_q) & sample_edge;
   assign can_shift  = active & (mode.cpha | in_word_q) & shift_edge;
   assign word_done  = can_sample & last_bit;
   assign bit_cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_word_q <= 1'b0;
         cnt_q     <= '0;
         tx_q      <= '0;
         rx_q      <= '0;
      end else if (!active) begin
         in_word_q <= 1'b0;
         cnt_q     <= '0;
      end else if (!mode.cpha && start) begin
         tx_q      <= tx_load;
         in_word_q <= 1'b1;
         cnt_q     <= '0;
      end else begin
         if (can_shift) begin
            if (mode.cpha && cnt_q == '0) tx_q <= tx_load;
            else                          tx_q <= tx_next;
         end
         if (can_sample) begin
            rx_q <= rx_next;
            if (last_bit) begin
               cnt_q <= '0;
               if (!mode.cpha) in_word_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + LEN_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MIN_LEN     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LEN_W      = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic              cfg_sel_high,
   input  logic [LEN_W-1:0]  cfg_word_len,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_write,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   input  logic              rx_read,
   output logic              rx_overrun,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   input  logic              spi_sel,
   output logic              spi_miso,
   output logic              spi_miso_oe
);

   if (MIN_LEN < 2 || MIN_LEN > DATA_W) begin : g_bad_len
      $error("spi_slave_core: MIN_LEN must lie in 2..DATA_W");
   end

   logic [LINK_N-1:0] link_raw, link_s;
   logic              sel_act, sel_start, sclk_rise, sclk_fall, lead, trail, sel_end;
   logic [LEN_W-1:0]  eff_len, bit_cnt;
   logic [DATA_W-1:0] tx_buf, rx_word;
   logic              word_done, drop;
   spi_mode_t         mode;

   assign link_raw[LINK_SCLK] = spi_sclk;
   assign link_raw[LINK_MOSI] = spi_mosi;
   assign link_raw[LINK_SEL]  = spi_sel;

   spi_slv_sync #(.WIDTH(LINK_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(link_raw), .q(link_s)
   );

   assign sel_act = cfg_enable & (cfg_sel_high ? link_s[LINK_SEL] : ~link_s[LINK_SEL]);

   spi_slv_edge #(.RST_VAL(1'b0)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .d(link_s[LINK_SCLK]), .rise(sclk_rise), .fall(sclk_fall)
   );
   spi_slv_edge #(.RST_VAL(1'b0)) u_sel_edge (
      .clk(clk), .rst_n(rst_n), .d(sel_act), .rise(sel_start), .fall(sel_end)
   );

   assign lead  = cfg_cpol ? sclk_fall : sclk_rise;
   assign trail = cfg_cpol ? sclk_rise : sclk_fall;

   assign eff_len = (cfg_word_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                    (cfg_word_len > LEN_W'(DATA_W))  ? LEN_W'(DATA_W)  : cfg_word_len;

   assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

   spi_slv_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(sel_act), .start(sel_start),
      .lead(lead), .trail(trail), .mode(mode), .len(eff_len),
      .mosi(link_s[LINK_MOSI]), .tx_buf(tx_buf), .miso_bit(spi_miso),
      .word_done(word_done), .rx_word(rx_word), .bit_cnt(bit_cnt)
   );

   // Transmit buffer accepts writes only while enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      tx_buf <= '0;
      else if (tx_write && cfg_enable) tx_buf <= tx_data;
   end

   // Receive holding register with full and overrun flags
   assign drop = word_done & rx_full & ~rx_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         rx_full    <= 1'b0;
         rx_overrun <= 1'b0;
      end else begin
         if (word_done && !drop) begin
            rx_data <= rx_word;
            rx_full <= 1'b1;
         end else if (rx_read) begin
            rx_full <= 1'b0;
         end
         if (drop)         rx_overrun <= 1'b1;
         else if (rx_read) rx_overrun <= 1'b0;
      end
   end

   assign spi_miso_oe = sel_act;

endmodule

// File: rtl/spi_slave_core_chk.sv
module spi_slave_core_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic              cfg_sel_high,
   input logic              spi_sel,
   input logic              spi_miso_oe,
   input logic              rx_read,
   input logic              rx_full,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_overrun,
   input logic              word_done,
   input logic [LEN_W-1:0]  bit_cnt,
   input logic [LEN_W-1:0]  eff_len
);

   logic [1:0] age;
   logic       raw_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assign raw_act = cfg_sel_high ? spi_sel : ~spi_sel;

   // R2: select inactive through the synchronizer depth means pad released
   assert_miso_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !raw_act && !$past(raw_act) && !$past(raw_act, 2)) |-> !spi_miso_oe);

   // R8: a read with no concurrent completion empties the register
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && !word_done) |=> !rx_full);

   // R9: unread data is held, even when a later word completes
   assert_hold_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_read) |=> (rx_full && $stable(rx_data)));

   // R9: overrun only appears on top of a full register
   assert_overrun_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $rose(rx_overrun)) |-> $past(rx_full));

   // R10: nothing lands while the engine is disabled
   assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !$past(cfg_enable)) |-> !$rose(rx_full));

   // R3: bit counter stays inside the clamped word length
   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt < eff_len) && (eff_len >= LEN_W'(8)) && (eff_len <= LEN_W'(DATA_W)));

endmodule

bind spi_slave_core spi_slave_core_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sel_high(cfg_sel_high),
   .spi_sel(spi_sel), .spi_miso_oe(spi_miso_oe), .rx_read(rx_read), .rx_full(rx_full),
   .rx_data(rx_data), .rx_overrun(rx_overrun), .word_done(word_done),
   .bit_cnt(bit_cnt), .eff_len(eff_len)
);

// File: tb/spi_slave_core_tb_top.sv
module spi_slave_core_tb_top;

   localparam int DATA_W = 32;
   localparam int LEN_W  = 6;
   localparam int HALF   = 8;

   logic              clk, rst_n;
   logic              cfg_enable, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_sel_high;
   logic [LEN_W-1:0]  cfg_word_len;
   logic [DATA_W-1:0] tx_data, rx_data;
   logic              tx_write, rx_full, rx_read, rx_overrun;
   logic              spi_sclk, spi_mosi, spi_sel, spi_miso, spi_miso_oe;

   int          checks = 0, errors = 0, rx_seen = 0;
   bit          mon_en = 1'b1;
   logic [31:0] exp_q[$];
   logic [31:0] last_tx;

   initial clk = 1'b0;
   always #2 clk = ~clk;

   spi_slave_core dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_sel_high(cfg_sel_high),
      .cfg_word_len(cfg_word_len), .tx_data(tx_data), .tx_write(tx_write),
      .rx_data(rx_data), .rx_full(rx_full), .rx_read(rx_read), .rx_overrun(rx_overrun),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_sel(spi_sel),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
   );

   function automatic int eff_len(int l);
      return (l < 8) ? 8 : ((l > 32) ? 32 : l);
   endfunction

   function automatic logic [31:0] mask_of(int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_sel(input bit on);
      spi_sel = on ? cfg_sel_high : ~cfg_sel_high;
      wclk(HALF);
   endtask

   task automatic write_tx(input logic [31:0] v);
      tx_data  = v;
      tx_write = 1'b1;
      wclk(1);
      tx_write = 1'b0;
      if (cfg_enable) last_tx = v;
   endtask

   task automatic set_mode(input bit cpol, input bit cpha, input bit lsb, input int len);
      cfg_cpol      = cpol;
      cfg_cpha      = cpha;
      cfg_lsb_first = lsb;
      cfg_word_len  = LEN_W'(len);
      spi_sclk      = cpol;
      wclk(4);
   endtask

   // Driver: acts as the master for one word, queues the expected receive word
   task automatic xfer_word(input logic [31:0] mo, input logic [31:0] exp_mi,
                            input bit push, input bit chk_mi, input string req);
      int          n;
      logic [31:0] mi;
      n  = eff_len(int'(cfg_word_len));
      mi = '0;
      if (push) exp_q.push_back(mo & mask_of(n));
      for (int i = 0; i < n; i++) begin
         int b;
         b = cfg_lsb_first ? i : n - 1 - i;
         if (!cfg_cpha) begin
            spi_mosi = mo[b];
            wclk(HALF);
            spi_sclk = ~cfg_cpol;
            mi[b]    = spi_miso;
            wclk(HALF);
            spi_sclk = cfg_cpol;
         end else begin
            spi_sclk = ~cfg_cpol;
            spi_mosi = mo[b];
            wclk(HALF);
            spi_sclk = cfg_cpol;
            mi[b]    = spi_miso;
            wclk(HALF);
         end
      end
      if (chk_mi) check(mi === (exp_mi & mask_of(n)), req, "miso word", mi, exp_mi & mask_of(n));
   endtask

   // Monitor: pops the scoreboard whenever a word is reported
   initial begin
      rx_read = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         if (mon_en && rx_full && !rx_read) begin
            rx_seen++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected word", rx_data, 32'h0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               check(rx_data === e, "R1/R4/R8", "rx word", rx_data, e);
            end
            rx_read = 1'b1;
         end else begin
            rx_read = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seen;
      rst_n = 1'b0; cfg_enable = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
      cfg_lsb_first = 1'b0; cfg_sel_high = 1'b0; cfg_word_len = 6'd8;
      spi_sel = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
      tx_data = '0; tx_write = 1'b0; last_tx = '0;
      wclk(5);
      rst_n = 1'b1;
      wclk(3);
      check(rx_full === 1'b0, "R8", "reset rx_full", {31'b0, rx_full}, 32'h0);
      check(rx_overrun === 1'b0, "R9", "reset overrun", {31'b0, rx_overrun}, 32'h0);
      check(spi_miso_oe === 1'b0, "R2", "reset oe", {31'b0, spi_miso_oe}, 32'h0);
      cfg_enable = 1'b1;
      wclk(4);

      // R1 R4 R6: idle low, sample leading, MSB first, 8 bits
      set_mode(0, 0, 0, 8);
      write_tx(32'hA5);
      set_sel(1);
      check(spi_miso_oe === 1'b1, "R2", "oe selected", {31'b0, spi_miso_oe}, 32'h1);
      xfer_word(32'h3C, 32'hA5, 1, 1, "R1 R4 R6");
      set_sel(0);
      wclk(4);
      check(spi_miso_oe === 1'b0, "R2", "oe released", {31'b0, spi_miso_oe}, 32'h0);

      // R6: extra clocks under the same select are ignored
      write_tx(32'h5A);
      set_sel(1);
      xfer_word(32'hC3, 32'h5A, 1, 1, "R6");
      wclk(16);
      seen = rx_seen;
      for (int k = 0; k < 8; k++) begin
         spi_sclk = ~cfg_cpol; spi_mosi = k[0]; wclk(HALF);
         spi_sclk = cfg_cpol;  wclk(HALF);
      end
      wclk(8);
      check(rx_seen == seen, "R6", "no second word", rx_seen, seen);
      set_sel(0);

      // R1 R4: idle high, sample leading, LSB first, 16 bits
      set_mode(1, 0, 1, 16);
      write_tx(32'h1234);
      set_sel(1);
      xfer_word(32'hBEEF, 32'h1234, 1, 1, "R1 R4");
      set_sel(0);

      // R7: idle low, sample trailing, MSB first, 32-bit burst of three
      set_mode(0, 1, 0, 32);
      write_tx(32'hDEAD_BEEF);
      set_sel(1);
      xfer_word(32'h0123_4567, 32'hDEAD_BEEF, 1, 1, "R7");
      write_tx(32'hCAFE_F00D);
      xfer_word(32'h89AB_CDEF, 32'hCAFE_F00D, 1, 1, "R7");
      write_tx(32'h0F0F_1234);
      xfer_word(32'h7654_3210, 32'h0F0F_1234, 1, 1, "R7");
      set_sel(0);

      // R1 R3 R4: idle high, sample trailing, LSB first, 13 bits
      set_mode(1, 1, 1, 13);
      write_tx(32'h0F5A);
      set_sel(1);
      xfer_word(32'h1ABC, 32'h0F5A, 1, 1, "R3 R4");
      set_sel(0);

      // R5: active-high select
      cfg_enable = 1'b0; wclk(2);
      cfg_sel_high = 1'b1; spi_sel = 1'b0; wclk(4);
      cfg_enable = 1'b1; wclk(4);
      set_mode(0, 0, 0, 8);
      check(spi_miso_oe === 1'b0, "R5", "oe with select low", {31'b0, spi_miso_oe}, 32'h0);
      write_tx(32'h96);
      set_sel(1);
      check(spi_miso_oe === 1'b1, "R5", "oe with select high", {31'b0, spi_miso_oe}, 32'h1);
      xfer_word(32'h69, 32'h96, 1, 1, "R5");
      set_sel(0);
      cfg_enable = 1'b0; wclk(2);
      cfg_sel_high = 1'b0; spi_sel = 1'b1; wclk(4);
      cfg_enable = 1'b1; wclk(4);

      // R3: clamping below and above the legal range
      set_mode(0, 0, 0, 4);
      write_tx(32'hF1);
      set_sel(1);
      xfer_word(32'h1E, 32'hF1, 1, 1, "R3 low clamp");
      set_sel(0);
      set_mode(0, 1, 1, 63);
      write_tx(32'h8421_1248);
      set_sel(1);
      xfer_word(32'hA5C3_3C5A, 32'h8421_1248, 1, 1, "R3 high clamp");
      set_sel(0);

      // R10: disabled engine ignores writes and link activity
      set_mode(0, 0, 0, 8);
      cfg_enable = 1'b0; wclk(2);
      write_tx(32'h77);
      seen = rx_seen;
      set_sel(1);
      check(spi_miso_oe === 1'b0, "R10", "oe while disabled", {31'b0, spi_miso_oe}, 32'h0);
      xfer_word(32'h55, 32'h0, 0, 0, "R10");
      set_sel(0);
      wclk(16);
      check(rx_seen == seen, "R10", "no word while disabled", rx_seen, seen);
      cfg_enable = 1'b1; wclk(4);
      set_sel(1);
      xfer_word(32'h33, last_tx, 1, 1, "R10 buffer kept");
      set_sel(0);

      // R9: overrun keeps the first word and flags the drop
      set_mode(0, 1, 0, 8);
      mon_en = 1'b0;
      write_tx(32'h11);
      set_sel(1);
      xfer_word(32'hA1, 32'h11, 1, 1, "R7");
      xfer_word(32'hB2, 32'h11, 0, 1, "R7");
      wclk(8);
      check(rx_full === 1'b1, "R8", "full held", {31'b0, rx_full}, 32'h1);
      check(rx_overrun === 1'b1, "R9", "overrun set", {31'b0, rx_overrun}, 32'h1);
      set_sel(0);
      mon_en = 1'b1;
      wclk(6);
      check(rx_overrun === 1'b0, "R9", "overrun cleared", {31'b0, rx_overrun}, 32'h0);
      check(rx_full === 1'b0, "R8", "full cleared", {31'b0, rx_full}, 32'h0);

      wclk(8);
      check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule